// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits on the device side of a byte-wide parallel NOR flash and turns bus write cycles into commands. Each accepted write carries a 19-bit address and an 8-bit data byte. The block looks for the two-write unlock prefix and the command byte that follows it. It then emits single-cycle start strobes for the embedded-operation controller: program, chip erase, sector erase, erase suspend, erase resume and command reset.

The block also holds the read mode that a downstream read multiplexer uses to choose between array data, identification codes, query data and erase-suspended array data. The controller reports back through three plain status pins: an operation is running, the running operation is an erase, and the operation has failed. The block uses these pins to lock out commands while work is in progress.

The write port has a valid/ready handshake, and `wr_ready` is held high. The block never applies back-pressure. Every cycle with `wr_valid` high is consumed in that cycle, including writes that are ignored.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `read_mode` is 0 (plain array) and every strobe output is low.
- R2: The unlock prefix is AAh written at address 555h followed by 55h written at address 2AAh. Only address bits 11:0 take part in the match, so bits 18:12 are ignored.
- R3: Unlock followed by A0h at 555h arms programming. The next write, whatever its address, raises `start_prog` for one cycle, one clock after that write. `prog_addr` and `prog_data` carry that write's address and data. An F0h data byte in this position aborts instead.
- R4: Unlock, 80h at 555h, unlock, then 10h at 555h raises `start_chip_erase` for one cycle.
- R5: Unlock, 80h at 555h, unlock, then 30h at any address raises `add_erase_sector` for one cycle. `erase_sector` equals address bits 18:16 of the last write.
- R6: Unlock followed by 90h at 555h sets `read_mode` to 1 (identification). A lone write of 98h at address 055h sets `read_mode` to 2 (query); this is accepted from array or identification mode.
- R7: A write of F0h at any address pulses `cmd_reset`, returns identification and query modes to array mode, and discards any partially entered sequence.
- R8: While `op_busy` is high and `op_fail` is low, every write is ignored, F0h included. The one exception is B0h while `erase_busy` is high and no suspend is in force: it pulses `suspend`, and `read_mode` becomes 3 (erase-suspended array).
- R9: While suspended and in array mode, a lone write of 30h at any address pulses `resume` and sets `read_mode` back to 0.
- R10: A reset from identification or query mode during a suspend sets `read_mode` to 3, not 0.
- R11: A write that does not match the expected step drops the sequence back to idle. Undefined bytes start no operation.
- R12: While `op_fail` is high, only F0h is accepted. It pulses `cmd_reset`, clears any suspend and sets `read_mode` to 0.
- R13: During a suspend the program sequence is still accepted, but the 80h erase setup is refused. In identification or query mode, neither program nor erase setup is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write cycle present |
| wr_ready | output | 1 | Always high; writes are never stalled |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| op_busy | input | 1 | Embedded operation running |
| erase_busy | input | 1 | The running operation is an erase |
| op_fail | input | 1 | Embedded operation failed |
| start_prog | output | 1 | Program start strobe |
| prog_addr | output | 19 | Program target address |
| prog_data | output | 8 | Program data |
| start_chip_erase | output | 1 | Chip erase start strobe |
| add_erase_sector | output | 1 | Sector erase strobe |
| erase_sector | output | 3 | Sector number for the erase strobe |
| suspend | output | 1 | Erase suspend strobe |
| resume | output | 1 | Erase resume strobe |
| cmd_reset | output | 1 | Accepted reset command strobe |
| read_mode | output | 2 | 0 array, 1 identification, 2 query, 3 erase-suspended array |

## Verification
The bench sends unlock writes with high address bits set. A design that compared the full address would never leave idle. It also sends F0h as the data of an armed program, where a wrong design would program F0h instead of aborting. A reset from identification mode during a suspend must come back in mode 3; a decoder without a separate suspend flag would fall to 0 and lose the parked erase. Writes of F0h while an operation is busy must not reach the controller, while B0h must get through, and a refused 80h during suspend must not start a nested erase.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERA1, ST_ERA2, ST_ERA3
  } step_e;

  typedef enum logic [1:0] {MD_ARRAY, MD_ID, MD_CFI} mode_e;

  localparam logic [1:0] RM_ARRAY = 2'd0;
  localparam logic [1:0] RM_ID    = 2'd1;
  localparam logic [1:0] RM_CFI   = 2'd2;
  localparam logic [1:0] RM_SUSP  = 2'd3;

  localparam logic [7:0] C_UNLK_A = 8'hAA;
  localparam logic [7:0] C_UNLK_B = 8'h55;
  localparam logic [7:0] C_ID     = 8'h90;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ERASE  = 8'h80;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_SECT   = 8'h30;
  localparam logic [7:0] C_RST    = 8'hF0;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_CFI    = 8'h98;

  localparam logic [11:0] A_FIRST  = 12'h555;
  localparam logic [11:0] A_SECOND = 12'h2AA;
  localparam logic [11:0] A_QUERY  = 12'h055;

  typedef struct packed {
    logic unl_a, unl_b, id, prog, erase, chip, sect, rst, susp, cfi;
  } hit_t;

  typedef struct packed {
    logic prog, chip, sect, id, cfi, rst, susp, resume;
  } ev_t;
endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CMP_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output hit_t              hit
);
  localparam logic [CMP_W-1:0] K_FIRST  = CMP_W'(A_FIRST);
  localparam logic [CMP_W-1:0] K_SECOND = CMP_W'(A_SECOND);
  localparam logic [CMP_W-1:0] K_QUERY  = CMP_W'(A_QUERY);

  logic [CMP_W-1:0] lo;
  logic at_first;
  assign lo       = addr[CMP_W-1:0];
  assign at_first = (lo == K_FIRST);

  always_comb begin
    hit.unl_a = at_first && (data == C_UNLK_A);
    hit.unl_b = (lo == K_SECOND) && (data == C_UNLK_B);
    hit.id    = at_first && (data == C_ID);
    hit.prog  = at_first && (data == C_PROG);
    hit.erase = at_first && (data == C_ERASE);
    hit.chip  = at_first && (data == C_CHIP);
    hit.sect  = (data == C_SECT);
    hit.rst   = (data == C_RST);
    hit.susp  = (data == C_SUSP);
    hit.cfi   = (lo == K_QUERY) && (data == C_CFI);
  end
endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ev_t        ev,
  input  logic       op_fail,
  output logic       in_array,
  output logic       allow_cfi,
  output logic       susp_q,
  output logic [1:0] read_mode
);
  mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_ARRAY;
      susp_q <= 1'b0;
    end else begin
      if (ev.rst) begin
        mode_q <= MD_ARRAY;
        if (op_fail) susp_q <= 1'b0;
      end else if (ev.id) begin
        mode_q <= MD_ID;
      end else if (ev.cfi) begin
        mode_q <= MD_CFI;
      end
      if (ev.susp)   susp_q <= 1'b1;
      if (ev.resume) susp_q <= 1'b0;
    end
  end

  assign in_array  = (mode_q == MD_ARRAY);
  assign allow_cfi = (mode_q != MD_CFI);

  always_comb begin
    unique case (mode_q)
      MD_ID:   read_mode = RM_ID;
      MD_CFI:  read_mode = RM_CFI;
      default: read_mode = susp_q ? RM_SUSP : RM_ARRAY;
    endcase
  end

  assert_susp_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_q && !$past(susp_q)) |-> $past(ev.susp));
  assert_reset_keeps_susp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.rst && susp_q && !op_fail) |=> (read_mode == RM_SUSP));
  assert_fail_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.rst && op_fail) |=> (read_mode == RM_ARRAY));
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  hit_t              hit,
  input  logic              op_busy,
  input  logic              op_fail,
  input  logic              erase_busy,
  input  logic              in_array,
  input  logic              allow_cfi,
  input  logic              susp_q,
  output ev_t               ev,
  output logic              start_prog,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              start_chip_erase,
  output logic              add_erase_sector,
  output logic [SECT_W-1:0] erase_sector,
  output logic              suspend,
  output logic              resume,
  output logic              cmd_reset
);
  step_e step_q, step_d;
  logic  locked;

  assign locked = op_busy && !op_fail;

  always_comb begin
    ev     = '0;
    step_d = step_q;
    if (wr_valid) begin
      if (locked) begin
        ev.susp = hit.susp && erase_busy && !susp_q;
      end else if (op_fail) begin
        if (hit.rst) begin
          ev.rst = 1'b1;
          step_d = ST_IDLE;
        end
      end else if (hit.rst) begin
        ev.rst = 1'b1;
        step_d = ST_IDLE;
      end else begin
        step_d = ST_IDLE;
        unique case (step_q)
          ST_IDLE: begin
            if (hit.unl_a)                      step_d = ST_UNL1;
            else if (hit.sect && susp_q && in_array) ev.resume = 1'b1;
            else if (hit.cfi && allow_cfi)      ev.cfi = 1'b1;
          end
          ST_UNL1: if (hit.unl_b) step_d = ST_UNL2;
          ST_UNL2: begin
            if (hit.id)                                ev.id = 1'b1;
            else if (hit.prog && in_array)             step_d = ST_PROG;
            else if (hit.erase && in_array && !susp_q) step_d = ST_ERA1;
          end
          ST_PROG: ev.prog = 1'b1;
          ST_ERA1: if (hit.unl_a) step_d = ST_ERA2;
          ST_ERA2: if (hit.unl_b) step_d = ST_ERA3;
          ST_ERA3: begin
            if (hit.chip)      ev.chip = 1'b1;
            else if (hit.sect) ev.sect = 1'b1;
          end
          default: step_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q           <= ST_IDLE;
      start_prog       <= 1'b0;
      start_chip_erase <= 1'b0;
      add_erase_sector <= 1'b0;
      suspend          <= 1'b0;
      resume           <= 1'b0;
      cmd_reset        <= 1'b0;
      prog_addr        <= '0;
      prog_data        <= '0;
      erase_sector     <= '0;
    end else begin
      step_q           <= step_d;
      start_prog       <= ev.prog;
      start_chip_erase <= ev.chip;
      add_erase_sector <= ev.sect;
      suspend          <= ev.susp;
      resume           <= ev.resume;
      cmd_reset        <= ev.rst;
      if (ev.prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (ev.sect) erase_sector <= wr_addr[ADDR_W-1 -: SECT_W];
    end
  end

  assert_busy_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && op_busy && !op_fail) |=>
      !(start_prog || start_chip_erase || add_erase_sector || resume || cmd_reset));
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_chip_erase, add_erase_sector, suspend, resume, cmd_reset}));
  assert_prog_after_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |-> $past(step_q == ST_PROG && wr_valid));
  assert_resume_needs_susp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> $past(susp_q));
  assert_fail_only_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && op_fail) |=>
      !(start_prog || start_chip_erase || add_erase_sector || suspend || resume));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3,
  parameter int CMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_busy,
  input  logic              erase_busy,
  input  logic              op_fail,
  output logic              start_prog,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              start_chip_erase,
  output logic              add_erase_sector,
  output logic [SECT_W-1:0] erase_sector,
  output logic              suspend,
  output logic              resume,
  output logic              cmd_reset,
  output logic [1:0]        read_mode
);
  hit_t hit;
  ev_t  ev;
  logic in_array, allow_cfi, susp_q;

  assign wr_ready = 1'b1;

  fcd_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_match (
    .addr(wr_addr), .data(wr_data), .hit(hit)
  );

  fcd_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .hit(hit), .op_busy(op_busy), .op_fail(op_fail),
    .erase_busy(erase_busy), .in_array(in_array), .allow_cfi(allow_cfi),
    .susp_q(susp_q), .ev(ev), .start_prog(start_prog), .prog_addr(prog_addr),
    .prog_data(prog_data), .start_chip_erase(start_chip_erase),
    .add_erase_sector(add_erase_sector), .erase_sector(erase_sector),
    .suspend(suspend), .resume(resume), .cmd_reset(cmd_reset)
  );

  fcd_mode u_mode (
    .clk(clk), .rst_n(rst_n), .ev(ev), .op_fail(op_fail),
    .in_array(in_array), .allow_cfi(allow_cfi), .susp_q(susp_q),
    .read_mode(read_mode)
  );

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, op_busy = 1'b0, erase_busy = 1'b0, op_fail = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_ready, start_prog, start_chip_erase, add_erase_sector;
  logic suspend, resume, cmd_reset;
  logic [18:0] prog_addr;
  logic [7:0]  prog_data;
  logic [2:0]  erase_sector;
  logic [1:0]  read_mode;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference state: step 0 idle,1 unl1,2 unl2,3 prog,4 era1,5 era2,6 era3
  int ms = 0, mm = 0;
  bit msus = 0;
  logic [5:0]  e_str;
  logic [18:0] e_pa;
  logic [7:0]  e_pd;
  logic [2:0]  e_sec;

  always #(PER/2) clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .op_busy(op_busy),
    .erase_busy(erase_busy), .op_fail(op_fail), .start_prog(start_prog),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .start_chip_erase(start_chip_erase), .add_erase_sector(add_erase_sector),
    .erase_sector(erase_sector), .suspend(suspend), .resume(resume),
    .cmd_reset(cmd_reset), .read_mode(read_mode)
  );

  function automatic logic [1:0] exp_mode();
    if (mm == 1) return 2'd1;
    if (mm == 2) return 2'd2;
    return msus ? 2'd3 : 2'd0;
  endfunction

  // strobe order: prog, chip, sect, susp, resume, reset
  task automatic model(input bit v, input logic [18:0] a, input logic [7:0] d);
    logic [11:0] lo;
    int nx;
    lo = a[11:0];
    e_str = '0;
    if (!v) return;
    if (op_busy && !op_fail) begin
      if (d == 8'hB0 && erase_busy && !msus) begin e_str[2] = 1; msus = 1; end
      return;
    end
    if (d == 8'hF0) begin
      e_str[0] = 1; mm = 0; ms = 0;
      if (op_fail) msus = 0;
      return;
    end
    if (op_fail) return;
    nx = 0;
    case (ms)
      0: if (d == 8'hAA && lo == 12'h555) nx = 1;
         else if (d == 8'h30 && msus && mm == 0) begin e_str[1] = 1; msus = 0; end
         else if (d == 8'h98 && lo == 12'h055 && mm != 2) mm = 2;
      1: if (d == 8'h55 && lo == 12'h2AA) nx = 2;
      2: if (lo == 12'h555) begin
           if (d == 8'h90) mm = 1;
           else if (d == 8'hA0 && mm == 0) nx = 3;
           else if (d == 8'h80 && mm == 0 && !msus) nx = 4;
         end
      3: begin e_str[5] = 1; e_pa = a; e_pd = d; end
      4: if (d == 8'hAA && lo == 12'h555) nx = 5;
      5: if (d == 8'h55 && lo == 12'h2AA) nx = 6;
      6: if (d == 8'h10 && lo == 12'h555) e_str[4] = 1;
         else if (d == 8'h30) begin e_str[3] = 1; e_sec = a[18:16]; end
      default: nx = 0;
    endcase
    ms = nx;
  endtask

  task automatic cyc(input bit v, input logic [18:0] a, input logic [7:0] d, input string tag);
    logic [5:0] act;
    bit ok;
    model(v, a, d);
    wr_valid = v; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 0;
    act = {start_prog, start_chip_erase, add_erase_sector, suspend, resume, cmd_reset};
    ok = (act == e_str) && (read_mode == exp_mode()) && wr_ready;
    if (e_str[5] && (prog_addr != e_pa || prog_data != e_pd)) ok = 0;
    if (e_str[3] && erase_sector != e_sec) ok = 0;
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: strobes=%b mode=%0d pa=%h pd=%h sec=%0d expected strobes=%b mode=%0d pa=%h pd=%h sec=%0d",
               tag, act, read_mode, prog_addr, prog_data, erase_sector,
               e_str, exp_mode(), e_pa, e_pd, e_sec);
    end
  endtask

  task automatic lit(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic unlock(input logic [18:0] hi, input string tag);
    cyc(1, hi | 19'h555, 8'hAA, tag);
    cyc(1, hi | 19'h2AA, 8'h55, tag);
  endtask

  function automatic logic [18:0] rnd_addr(input logic [11:0] lo);
    logic [18:0] r;
    r = 19'($urandom);
    return {r[18:12], lo};
  endfunction

  initial begin
    #(PER * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    e_pa = '0; e_pd = '0; e_sec = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    lit({30'd0, read_mode}, 0, "R1 mode");
    lit({26'd0, start_prog, start_chip_erase, add_erase_sector, suspend, resume, cmd_reset}, 0, "R1 strobes");
    cyc(0, 0, 0, "R1 idle");

    // R2 R3: unlock with high bits set, then program
    unlock(19'h7F000, "R2 unlock");
    cyc(1, 19'h3A555, 8'hA0, "R3 arm");
    cyc(1, 19'h41234, 8'h5C, "R3 program");
    lit({31'd0, start_prog}, 1, "R3 strobe");
    lit({13'd0, prog_addr}, 32'h41234, "R3 addr");
    lit({24'd0, prog_data}, 32'h5C, "R3 data");

    // R4 chip erase
    unlock(0, "R4"); cyc(1, 19'h555, 8'h80, "R4");
    unlock(0, "R4"); cyc(1, 19'h555, 8'h10, "R4 chip");
    lit({31'd0, start_chip_erase}, 1, "R4 strobe");

    // R5 sector erase
    unlock(0, "R5"); cyc(1, 19'h555, 8'h80, "R5");
    unlock(0, "R5"); cyc(1, 19'h51234, 8'h30, "R5 sector");
    lit({31'd0, add_erase_sector}, 1, "R5 strobe");
    lit({29'd0, erase_sector}, 5, "R5 sector no");

    // R6 ID then R7 reset
    unlock(0, "R6"); cyc(1, 19'h555, 8'h90, "R6 id");
    lit({30'd0, read_mode}, 1, "R6 id mode");
    cyc(1, 19'h12345, 8'hF0, "R7 reset");
    lit({30'd0, read_mode}, 0, "R7 mode"); lit({31'd0, cmd_reset}, 1, "R7 strobe");
    cyc(1, 19'h00055, 8'h98, "R6 cfi");
    lit({30'd0, read_mode}, 2, "R6 cfi mode");
    // R13: program refused in query mode
    unlock(0, "R13"); cyc(1, 19'h555, 8'hA0, "R13"); cyc(1, 19'h100, 8'h00, "R13 no prog");
    cyc(1, 0, 8'hF0, "R7");

    // R7 abort armed program with F0 as data
    unlock(0, "R7"); cyc(1, 19'h555, 8'hA0, "R7");
    cyc(1, 19'h1000, 8'hF0, "R7 abort");
    cyc(1, 19'h1000, 8'h12, "R7 no prog");
    lit({31'd0, start_prog}, 0, "R7 no prog strobe");

    // R11 mismatch
    cyc(1, 19'h555, 8'hAA, "R11"); cyc(1, 19'h2AB, 8'h55, "R11 bad addr");
    cyc(1, 19'h555, 8'h90, "R11 no id");
    lit({30'd0, read_mode}, 0, "R11 mode");

    // R8 busy lock and suspend
    op_busy = 1; erase_busy = 1;
    cyc(1, 0, 8'hF0, "R8 reset ignored");
    lit({31'd0, cmd_reset}, 0, "R8 no reset");
    cyc(1, 19'h7, 8'hB0, "R8 suspend");
    lit({30'd0, read_mode}, 3, "R8 susp mode");
    op_busy = 0; erase_busy = 0;

    // R13 during suspend: erase setup refused, program accepted
    unlock(0, "R13"); cyc(1, 19'h555, 8'h80, "R13 no erase");
    unlock(0, "R13"); cyc(1, 19'h555, 8'h10, "R13 no chip");
    lit({31'd0, start_chip_erase}, 0, "R13 chip refused");
    unlock(0, "R13"); cyc(1, 19'h555, 8'hA0, "R13"); cyc(1, 19'h20, 8'h0F, "R13 prog in susp");

    // R10 reset from ID during suspend
    unlock(0, "R10"); cyc(1, 19'h555, 8'h90, "R10 id");
    cyc(1, 0, 8'hF0, "R10 reset");
    lit({30'd0, read_mode}, 3, "R10 back to susp");

    // R9 resume
    cyc(1, 19'h6ABCD, 8'h30, "R9 resume");
    lit({31'd0, resume}, 1, "R9 strobe"); lit({30'd0, read_mode}, 0, "R9 mode");

    // R12 fail state
    op_busy = 1; op_fail = 1;
    unlock(0, "R12 ignored"); cyc(1, 19'h555, 8'h90, "R12 no id");
    cyc(1, 0, 8'hF0, "R12 reset");
    lit({31'd0, cmd_reset}, 1, "R12 strobe");
    op_busy = 0; op_fail = 0;

    // random traffic checked against the reference model (R11 and all)
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] d; logic [18:0] a; int k;
      k = $urandom_range(0, 12);
      case (k)
        0, 1: begin a = rnd_addr(12'h555); d = 8'hAA; end
        2, 3: begin a = rnd_addr(12'h2AA); d = 8'h55; end
        4: begin a = rnd_addr(12'h555); d = 8'h90; end
        5: begin a = rnd_addr(12'h555); d = 8'hA0; end
        6: begin a = rnd_addr(12'h555); d = 8'h80; end
        7: begin a = rnd_addr(12'h555); d = 8'h10; end
        8: begin a = 19'($urandom); d = 8'h30; end
        9: begin a = 19'($urandom); d = 8'hF0; end
        10: begin a = 19'($urandom); d = 8'hB0; end
        11: begin a = rnd_addr(12'h055); d = 8'h98; end
        default: begin a = 19'($urandom); d = 8'($urandom); end
      endcase
      op_busy    = ($urandom_range(0, 9) < 2);
      erase_busy = op_busy && $urandom_range(0, 1);
      op_fail    = op_busy && ($urandom_range(0, 9) == 0);
      cyc($urandom_range(0, 7) != 0, a, d, "R11 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule